// File: doc/BRIEF.md
# Pipeline hazard control unit

This block is the hazard logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It looks at the register indices, the register-write flags and the load/store flags held in each pipeline register, plus the branch outcome computed in decode. From these it produces:

- the operand bypass selects for the execute stage,
- a forward select for the branch comparator in decode,
- a hold for the PC and the fetch/decode register,
- a bubble insert for the execute stage,
- a squash-and-redirect for fetch,
- a fetch-void signal for a shared memory port.

All outputs are combinational functions of the current pipeline contents. Multi-cycle stalls come from the pipeline moving forward while the same conditions stay true.

Branches are compared and their targets computed in decode, and branches are predicted not taken. Two build-time switches change the variant. `BYPASS_EN` removes the bypass network, so dependents wait for writeback. `SHARED_MEM` models a single memory shared by fetch and data access.

The register file writes in the first half of a cycle. A reader three instructions behind its producer therefore needs neither a bypass nor a stall.

Top module: `hazard_ctrl`

## Requirements
- R1: With bypass on, when the EX/MEM register writes a nonzero register equal to an execute-stage source, that source's select is 2'b01 (EX/MEM result), and no stall is raised.
- R2: With bypass on, when only the MEM/WB register matches an execute-stage source, the select is 2'b10 (MEM/WB value). When both registers match, 2'b01 wins. With no match, the select is 2'b00 (register file).
- R3: Register 0 never raises a stall, never selects a bypass and never drives a decode forward.
- R4: A load in execute whose nonzero destination equals a decode source raises hold and bubble for exactly that cycle. Once the load sits in memory, a non-branch consumer in decode is not held.
- R5: A branch in decode raises hold and bubble when a source matches the destination of any writing instruction in execute. It also stalls on a load in memory with a matching destination, so a load producer costs two stall cycles. A non-load producer in memory is instead forwarded to the comparator, with the decode forward bit set to 1.
- R6: A decode source matching only the writeback-stage destination raises no stall and no decode forward.
- R7: squash is 1 exactly when decode holds a branch resolved taken and the front end is not held. A not-taken branch never squashes.
- R8: With bypass off, all selects are 2'b00. A decode source matching a writing destination in execute or memory raises hold, so back-to-back dependent instructions stall two cycles.
- R9: With the shared-memory build, fetch_void is 1 when the memory stage holds a load or a store and there is neither a hold nor a squash. The default build never raises fetch_void.
- R10: At most one of hold, fetch_void and squash is 1 at a time, and bubble_ex equals hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_AW | Decode-stage first source index |
| id_rs2_i | input | REG_AW | Decode-stage second source index |
| id_branch_i | input | 1 | Decode holds a conditional branch |
| id_taken_i | input | 1 | Decode comparator says taken |
| ex_rs1_i | input | REG_AW | Execute-stage first source index |
| ex_rs2_i | input | REG_AW | Execute-stage second source index |
| ex_rd_i | input | REG_AW | Execute-stage destination index |
| ex_regwr_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | REG_AW | Memory-stage destination index |
| mem_regwr_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| mem_store_i | input | 1 | Memory-stage instruction is a store |
| wb_rd_i | input | REG_AW | Writeback-stage destination index |
| wb_regwr_i | input | 1 | Writeback-stage instruction writes a register |
| ex_fwd_a_o | output | 2 | First execute operand select (00 reg file, 01 EX/MEM, 10 MEM/WB) |
| ex_fwd_b_o | output | 2 | Second execute operand select, same code |
| id_fwd_a_o | output | 1 | Branch comparator first operand from EX/MEM result |
| id_fwd_b_o | output | 1 | Branch comparator second operand from EX/MEM result |
| hold_o | output | 1 | Hold PC and fetch/decode register |
| bubble_ex_o | output | 1 | Insert a bubble into execute |
| squash_o | output | 1 | Void fetched instruction and redirect fetch to the branch target |
| fetch_void_o | output | 1 | Memory port busy; PC holds and decode receives a bubble |

## Verification
The bench goes after the load-use window and checks that the stall lasts one cycle and not two. A unit that also stalled on a load in memory would cost an extra cycle on every load, and one that forgot the case would let the consumer read a stale value.

It checks the priority between the two bypass sources. It also sweeps every register index against a load destination, because a missing zero filter shows up only on register 0.

It follows branches whose producer is in execute or in memory, for both ALU and load producers. It checks that a stalled branch never squashes and that a taken branch with no stall does. It also checks that the shared-memory variant yields to a squash instead of raising two front-end actions together.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic [1:0] {
      FWD_REG = 2'b00,
      FWD_EXM = 2'b01,
      FWD_MWB = 2'b10
   } fwd_sel_t;
endpackage

// File: rtl/hzd_bypass.sv
module hzd_bypass
   import hzd_pkg::*;
#(
   parameter int AW        = 5,
   parameter int NSRC      = 2,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic [NSRC-1:0][AW-1:0] ex_src_i,
   input  logic [NSRC-1:0][AW-1:0] id_src_i,
   input  logic [AW-1:0]           mem_rd_i,
   input  logic                    mem_wr_i,
   input  logic                    mem_ld_i,
   input  logic [AW-1:0]           wb_rd_i,
   input  logic                    wb_wr_i,
   output logic [NSRC-1:0][1:0]    ex_sel_o,
   output logic [NSRC-1:0]         id_sel_o
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   if (BYPASS_EN) begin : g_on
      for (genvar k = 0; k < NSRC; k++) begin : g_src
         logic mem_hit;
         logic wb_hit;
         assign mem_hit = mem_wr_i && (mem_rd_i != ZERO_REG) && (mem_rd_i == ex_src_i[k]);
         assign wb_hit  = wb_wr_i && (wb_rd_i != ZERO_REG) && (wb_rd_i == ex_src_i[k]);
         assign ex_sel_o[k] = mem_hit ? FWD_EXM : (wb_hit ? FWD_MWB : FWD_REG);
         assign id_sel_o[k] = mem_wr_i && !mem_ld_i && (mem_rd_i != ZERO_REG)
                              && (mem_rd_i == id_src_i[k]);
      end
   end else begin : g_off
      assign ex_sel_o = '0;
      assign id_sel_o = '0;
   end

   for (genvar k = 0; k < NSRC; k++) begin : g_chk
      always_comb begin
         if (ex_src_i[k] == ZERO_REG)
            a_r3_no_zero_bypass: assert (ex_sel_o[k] == FWD_REG)
               else $error("R3 bypass selected for register 0");
         if (id_src_i[k] == ZERO_REG)
            a_r3_no_zero_dec_fwd: assert (!id_sel_o[k])
               else $error("R3 decode forward for register 0");
         if (ex_sel_o[k] == FWD_MWB)
            a_r2_older_loses: assert (wb_wr_i && !(mem_wr_i && mem_rd_i == ex_src_i[k]))
               else $error("R2 MEM/WB chosen over matching EX/MEM");
         if (id_sel_o[k])
            a_r5_no_load_dec_fwd: assert (!mem_ld_i)
               else $error("R5 load value forwarded to decode");
      end
   end
endmodule

// File: rtl/hzd_stall.sv
module hzd_stall #(
   parameter int AW        = 5,
   parameter int NSRC      = 2,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic [NSRC-1:0][AW-1:0] id_src_i,
   input  logic                    id_branch_i,
   input  logic [AW-1:0]           ex_rd_i,
   input  logic                    ex_wr_i,
   input  logic                    ex_ld_i,
   input  logic [AW-1:0]           mem_rd_i,
   input  logic                    mem_wr_i,
   input  logic                    mem_ld_i,
   output logic                    stall_o
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   logic [NSRC-1:0] ex_hit_v;
   logic [NSRC-1:0] mem_hit_v;
   logic            ex_hit;
   logic            mem_hit;

   for (genvar k = 0; k < NSRC; k++) begin : g_cmp
      assign ex_hit_v[k]  = (ex_rd_i != ZERO_REG) && (ex_rd_i == id_src_i[k]);
      assign mem_hit_v[k] = (mem_rd_i != ZERO_REG) && (mem_rd_i == id_src_i[k]);
   end
   assign ex_hit  = |ex_hit_v;
   assign mem_hit = |mem_hit_v;

   if (BYPASS_EN) begin : g_fwd
      logic load_use;
      logic br_on_ex;
      logic br_on_mem_ld;
      assign load_use     = ex_wr_i && ex_ld_i && ex_hit;
      assign br_on_ex     = id_branch_i && ex_wr_i && ex_hit;
      assign br_on_mem_ld = id_branch_i && mem_wr_i && mem_ld_i && mem_hit;
      assign stall_o      = load_use || br_on_ex || br_on_mem_ld;
   end else begin : g_wait
      assign stall_o = (ex_wr_i && ex_hit) || (mem_wr_i && mem_hit);
   end

   always_comb begin
      if (ex_wr_i && ex_ld_i && ex_hit)
         a_r4_load_use_stalls: assert (stall_o)
            else $error("R4 load-use without stall");
      if (id_branch_i && mem_wr_i && mem_ld_i && mem_hit)
         a_r5_branch_waits_load: assert (stall_o)
            else $error("R5 branch compared against unfinished load");
      if (id_src_i == '0)
         a_r3_zero_no_stall: assert (!stall_o)
            else $error("R3 stall on register 0 sources");
   end
endmodule

// File: rtl/hzd_front.sv
module hzd_front #(
   parameter bit SHARED_MEM = 1'b0
) (
   input  logic stall_i,
   input  logic branch_i,
   input  logic taken_i,
   input  logic mem_ld_i,
   input  logic mem_st_i,
   output logic hold_o,
   output logic bubble_o,
   output logic squash_o,
   output logic fvoid_o
);
   assign hold_o   = stall_i;
   assign bubble_o = stall_i;
   assign squash_o = branch_i && taken_i && !stall_i;

   if (SHARED_MEM) begin : g_shared
      assign fvoid_o = (mem_ld_i || mem_st_i) && !stall_i && !squash_o;
   end else begin : g_split
      assign fvoid_o = 1'b0;
   end

   always_comb begin
      a_r10_one_front_action: assert ($onehot0({hold_o, fvoid_o, squash_o}))
         else $error("R10 conflicting front-end actions");
      a_r10_bubble_with_hold: assert (bubble_o == hold_o)
         else $error("R10 bubble and hold disagree");
      if (squash_o)
         a_r7_squash_needs_taken: assert (branch_i && taken_i)
            else $error("R7 squash without taken branch");
      if (fvoid_o)
         a_r9_void_needs_access: assert (mem_ld_i || mem_st_i)
            else $error("R9 fetch voided with idle memory");
   end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
   import hzd_pkg::*;
#(
   parameter int REG_AW     = 5,
   parameter bit BYPASS_EN  = 1'b1,
   parameter bit SHARED_MEM = 1'b0
) (
   input  logic [REG_AW-1:0] id_rs1_i,
   input  logic [REG_AW-1:0] id_rs2_i,
   input  logic              id_branch_i,
   input  logic              id_taken_i,
   input  logic [REG_AW-1:0] ex_rs1_i,
   input  logic [REG_AW-1:0] ex_rs2_i,
   input  logic [REG_AW-1:0] ex_rd_i,
   input  logic              ex_regwr_i,
   input  logic              ex_load_i,
   input  logic [REG_AW-1:0] mem_rd_i,
   input  logic              mem_regwr_i,
   input  logic              mem_load_i,
   input  logic              mem_store_i,
   input  logic [REG_AW-1:0] wb_rd_i,
   input  logic              wb_regwr_i,
   output logic [1:0]        ex_fwd_a_o,
   output logic [1:0]        ex_fwd_b_o,
   output logic              id_fwd_a_o,
   output logic              id_fwd_b_o,
   output logic              hold_o,
   output logic              bubble_ex_o,
   output logic              squash_o,
   output logic              fetch_void_o
);
   localparam int NSRC = 2;

   initial begin
      a_cfg_reg_width: assert (REG_AW >= 1 && REG_AW <= 8)
         else $error("REG_AW out of range");
   end

   logic [NSRC-1:0][REG_AW-1:0] ex_src;
   logic [NSRC-1:0][REG_AW-1:0] id_src;
   logic [NSRC-1:0][1:0]        ex_sel;
   logic [NSRC-1:0]             id_sel;
   logic                        stall;

   assign ex_src = {ex_rs2_i, ex_rs1_i};
   assign id_src = {id_rs2_i, id_rs1_i};

   hzd_bypass #(.AW(REG_AW), .NSRC(NSRC), .BYPASS_EN(BYPASS_EN)) u_bypass (
      .ex_src_i (ex_src),
      .id_src_i (id_src),
      .mem_rd_i (mem_rd_i),
      .mem_wr_i (mem_regwr_i),
      .mem_ld_i (mem_load_i),
      .wb_rd_i  (wb_rd_i),
      .wb_wr_i  (wb_regwr_i),
      .ex_sel_o (ex_sel),
      .id_sel_o (id_sel)
   );

   hzd_stall #(.AW(REG_AW), .NSRC(NSRC), .BYPASS_EN(BYPASS_EN)) u_stall (
      .id_src_i    (id_src),
      .id_branch_i (id_branch_i),
      .ex_rd_i     (ex_rd_i),
      .ex_wr_i     (ex_regwr_i),
      .ex_ld_i     (ex_load_i),
      .mem_rd_i    (mem_rd_i),
      .mem_wr_i    (mem_regwr_i),
      .mem_ld_i    (mem_load_i),
      .stall_o     (stall)
   );

   hzd_front #(.SHARED_MEM(SHARED_MEM)) u_front (
      .stall_i  (stall),
      .branch_i (id_branch_i),
      .taken_i  (id_taken_i),
      .mem_ld_i (mem_load_i),
      .mem_st_i (mem_store_i),
      .hold_o   (hold_o),
      .bubble_o (bubble_ex_o),
      .squash_o (squash_o),
      .fvoid_o  (fetch_void_o)
   );

   assign ex_fwd_a_o = ex_sel[0];
   assign ex_fwd_b_o = ex_sel[1];
   assign id_fwd_a_o = id_sel[0];
   assign id_fwd_b_o = id_sel[1];

   always_comb begin
      if (ex_fwd_a_o != 2'b00 || ex_fwd_b_o != 2'b00)
         a_r8_no_bypass_when_off: assert (BYPASS_EN)
            else $error("R8 bypass select in no-bypass build");
      if (wb_regwr_i && !ex_regwr_i && !mem_regwr_i)
         a_r6_writeback_free: assert (!hold_o)
            else $error("R6 stall with only writeback producer");
   end
endmodule

// File: tb/hazard_ctrl_tb.sv
`timescale 1ns/1ps
module hazard_ctrl_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   typedef struct packed {
      logic [4:0] irs1, irs2; logic br, tk;
      logic [4:0] ers1, ers2, erd; logic ewr, eld;
      logic [4:0] mrd; logic mwr, mld, mst;
      logic [4:0] wrd; logic wwr;
      logic [1:0] xfa, xfb; logic ifa, ifb, hold, sq, nbhold, shvoid;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{0,0,0,0,  0,0,0,0,0,   0,0,0,0,  0,0,  0,0,0,0,0,0,0,0}, // idle, R10
      '{0,0,0,0,  3,4,0,0,0,   3,1,0,0,  0,0,  1,0,0,0,0,0,0,0}, // R1
      '{0,0,0,0,  5,6,0,0,0,   5,1,0,0,  5,1,  1,0,0,0,0,0,0,0}, // R2 priority
      '{0,0,0,0,  0,7,0,0,0,   9,1,0,0,  7,1,  0,2,0,0,0,0,0,0}, // R2 MEM/WB
      '{0,0,1,1,  0,0,0,1,1,   0,1,0,0,  0,1,  0,0,0,0,0,1,0,0}, // R3, R7
      '{8,2,0,0,  0,0,2,1,1,   0,0,0,0,  0,0,  0,0,0,0,1,0,1,0}, // R4 first cycle
      '{0,2,0,0,  0,0,0,0,0,   2,1,1,0,  0,0,  0,0,0,0,0,0,1,1}, // R4 second, R9
      '{10,0,1,1, 0,0,10,1,0,  0,0,0,0,  0,0,  0,0,0,0,1,0,1,0}, // R5 EX ALU
      '{0,11,1,1, 0,0,0,0,0,   11,1,0,0, 0,0,  0,0,0,1,0,1,1,0}, // R5 MEM ALU fwd
      '{12,0,1,0, 0,0,0,0,0,   12,1,1,0, 0,0,  0,0,0,0,1,0,1,0}, // R5 MEM load
      '{13,0,1,0, 0,0,0,0,0,   0,0,0,0,  13,1, 0,0,0,0,0,0,0,0}, // R6
      '{0,0,0,0,  0,0,0,0,0,   0,0,0,1,  0,0,  0,0,0,0,0,0,0,1}, // R9 store
      '{0,0,1,1,  0,0,0,0,0,   0,0,0,1,  0,0,  0,0,0,0,0,1,0,0}, // R9 vs squash
      '{14,0,0,0, 0,0,14,1,0,  0,0,0,0,  0,0,  0,0,0,0,0,0,1,0}  // R8
   };

   logic [4:0] irs1, irs2, ers1, ers2, erd, mrd, wrd;
   logic br, tk, ewr, eld, mwr, mld, mst, wwr;

   logic [1:0] d_xfa, d_xfb, n_xfa, n_xfb, s_xfa, s_xfb;
   logic d_ifa, d_ifb, d_hold, d_bub, d_sq, d_fv;
   logic n_ifa, n_ifb, n_hold, n_bub, n_sq, n_fv;
   logic s_ifa, s_ifb, s_hold, s_bub, s_sq, s_fv;

   hazard_ctrl u_dut (
      .id_rs1_i(irs1), .id_rs2_i(irs2), .id_branch_i(br), .id_taken_i(tk),
      .ex_rs1_i(ers1), .ex_rs2_i(ers2), .ex_rd_i(erd), .ex_regwr_i(ewr), .ex_load_i(eld),
      .mem_rd_i(mrd), .mem_regwr_i(mwr), .mem_load_i(mld), .mem_store_i(mst),
      .wb_rd_i(wrd), .wb_regwr_i(wwr),
      .ex_fwd_a_o(d_xfa), .ex_fwd_b_o(d_xfb), .id_fwd_a_o(d_ifa), .id_fwd_b_o(d_ifb),
      .hold_o(d_hold), .bubble_ex_o(d_bub), .squash_o(d_sq), .fetch_void_o(d_fv));

   hazard_ctrl #(.BYPASS_EN(1'b0)) u_dut_nobyp (
      .id_rs1_i(irs1), .id_rs2_i(irs2), .id_branch_i(br), .id_taken_i(tk),
      .ex_rs1_i(ers1), .ex_rs2_i(ers2), .ex_rd_i(erd), .ex_regwr_i(ewr), .ex_load_i(eld),
      .mem_rd_i(mrd), .mem_regwr_i(mwr), .mem_load_i(mld), .mem_store_i(mst),
      .wb_rd_i(wrd), .wb_regwr_i(wwr),
      .ex_fwd_a_o(n_xfa), .ex_fwd_b_o(n_xfb), .id_fwd_a_o(n_ifa), .id_fwd_b_o(n_ifb),
      .hold_o(n_hold), .bubble_ex_o(n_bub), .squash_o(n_sq), .fetch_void_o(n_fv));

   hazard_ctrl #(.SHARED_MEM(1'b1)) u_dut_shmem (
      .id_rs1_i(irs1), .id_rs2_i(irs2), .id_branch_i(br), .id_taken_i(tk),
      .ex_rs1_i(ers1), .ex_rs2_i(ers2), .ex_rd_i(erd), .ex_regwr_i(ewr), .ex_load_i(eld),
      .mem_rd_i(mrd), .mem_regwr_i(mwr), .mem_load_i(mld), .mem_store_i(mst),
      .wb_rd_i(wrd), .wb_regwr_i(wwr),
      .ex_fwd_a_o(s_xfa), .ex_fwd_b_o(s_xfb), .id_fwd_a_o(s_ifa), .id_fwd_b_o(s_ifb),
      .hold_o(s_hold), .bubble_ex_o(s_bub), .squash_o(s_sq), .fetch_void_o(s_fv));

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic chk(input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", what, got, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      irs1 = v.irs1; irs2 = v.irs2; br = v.br; tk = v.tk;
      ers1 = v.ers1; ers2 = v.ers2; erd = v.erd; ewr = v.ewr; eld = v.eld;
      mrd = v.mrd; mwr = v.mwr; mld = v.mld; mst = v.mst;
      wrd = v.wrd; wwr = v.wwr;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      vec_t v;
      v = '0;
      apply(v);
      @(negedge clk);
      // R10 idle state: no front-end action at all
      chk("R10 idle hold", d_hold, 0);
      chk("R10 idle squash", d_sq, 0);
      chk("R10 idle fetch_void", s_fv, 0);

      for (int i = 0; i < NV; i++) begin
         @(posedge clk);
         apply(VEC[i]);
         @(negedge clk);
         chk($sformatf("R1/R2 vec%0d ex_fwd_a", i), d_xfa, VEC[i].xfa);
         chk($sformatf("R1/R2 vec%0d ex_fwd_b", i), d_xfb, VEC[i].xfb);
         chk($sformatf("R5 vec%0d id_fwd_a", i), d_ifa, VEC[i].ifa);
         chk($sformatf("R5 vec%0d id_fwd_b", i), d_ifb, VEC[i].ifb);
         chk($sformatf("R4/R5 vec%0d hold", i), d_hold, VEC[i].hold);
         chk($sformatf("R10 vec%0d bubble", i), d_bub, VEC[i].hold);
         chk($sformatf("R7 vec%0d squash", i), d_sq, VEC[i].sq);
         chk($sformatf("R9 vec%0d default fetch_void", i), d_fv, 0);
         chk($sformatf("R8 vec%0d nobyp hold", i), n_hold, VEC[i].nbhold);
         chk($sformatf("R8 vec%0d nobyp selects", i),
             {n_xfa, n_xfb, n_ifa, n_ifb}, 0);
         chk($sformatf("R9 vec%0d shmem fetch_void", i), s_fv, VEC[i].shvoid);
         chk($sformatf("R10 vec%0d exclusive", i),
             int'(d_hold) + int'(d_sq) + int'(d_fv) <= 1, 1);
      end

      // R3 / R4: sweep every register index as a load destination
      for (int r = 0; r < 32; r++) begin
         @(posedge clk);
         v = '0;
         v.irs2 = 5'(r); v.erd = 5'(r); v.ewr = 1'b1; v.eld = 1'b1;
         apply(v);
         @(negedge clk);
         chk($sformatf("R3/R4 load-use reg %0d hold", r), d_hold, (r != 0) ? 1 : 0);
      end

      // R4 sequence: load then dependent ALU, count stall cycles
      begin
         int stalls;
         stalls = 0;
         @(posedge clk);
         v = '0; v.irs1 = 5'd17; v.erd = 5'd17; v.ewr = 1'b1; v.eld = 1'b1;
         apply(v);
         @(negedge clk); stalls += int'(d_hold);
         @(posedge clk);
         v = '0; v.irs1 = 5'd17; v.mrd = 5'd17; v.mwr = 1'b1; v.mld = 1'b1;
         apply(v);
         @(negedge clk); stalls += int'(d_hold);
         chk("R4 load-use stall cycles", stalls, 1);
         @(posedge clk);
         v = '0; v.ers1 = 5'd17; v.wrd = 5'd17; v.wwr = 1'b1;
         apply(v);
         @(negedge clk);
         chk("R4 consumer takes MEM/WB value", d_xfa, 2);
      end

      // R8 sequence: ALU producer then consumer with bypass off
      begin
         int stalls;
         stalls = 0;
         @(posedge clk);
         v = '0; v.irs2 = 5'd20; v.erd = 5'd20; v.ewr = 1'b1;
         apply(v);
         @(negedge clk); stalls += int'(n_hold);
         chk("R1 bypass build no stall", d_hold, 0);
         @(posedge clk);
         v = '0; v.irs2 = 5'd20; v.mrd = 5'd20; v.mwr = 1'b1;
         apply(v);
         @(negedge clk); stalls += int'(n_hold);
         @(posedge clk);
         v = '0; v.irs2 = 5'd20; v.wrd = 5'd20; v.wwr = 1'b1;
         apply(v);
         @(negedge clk); stalls += int'(n_hold);
         chk("R8 no-bypass stall cycles", stalls, 2);
         chk("R6 writeback producer no stall", n_hold, 0);
      end

      // R5 sequence: load feeding a branch, two stalls then taken squash
      begin
         int stalls;
         stalls = 0;
         @(posedge clk);
         v = '0; v.br = 1'b1; v.tk = 1'b1; v.irs1 = 5'd22;
         v.erd = 5'd22; v.ewr = 1'b1; v.eld = 1'b1;
         apply(v);
         @(negedge clk); stalls += int'(d_hold);
         chk("R7 no squash while held", d_sq, 0);
         @(posedge clk);
         v = '0; v.br = 1'b1; v.tk = 1'b1; v.irs1 = 5'd22;
         v.mrd = 5'd22; v.mwr = 1'b1; v.mld = 1'b1;
         apply(v);
         @(negedge clk); stalls += int'(d_hold);
         @(posedge clk);
         v = '0; v.br = 1'b1; v.tk = 1'b1; v.irs1 = 5'd22;
         v.wrd = 5'd22; v.wwr = 1'b1;
         apply(v);
         @(negedge clk); stalls += int'(d_hold);
         chk("R5 load-to-branch stall cycles", stalls, 2);
         chk("R7 squash after resolve", d_sq, 1);
      end

      @(posedge clk);
      finish_run();
   end
endmodule